// File: doc/BRIEF.md
# Oversampled Weighted Overlap-Add Synthesis Stage

This block finishes the synthesis half of an oversampled filterbank. An inverse transform, outside the block, delivers one time-domain frame of N samples at a time. The block stores the frame and undoes the circular rotation that the analysis side applied to the frame with the same index. It repeats the frame periodically to fill a short synthesis window of W = L*R/N taps, can flip the sign of alternate taps for odd-stacked banks, and multiplies each tap by a programmable coefficient. The weighted frame is added into an overlap-add accumulator of W entries.

After each frame the R oldest accumulator entries are rounded, saturated to the sample width and streamed out. The accumulator then moves down by R places and zeros enter at the top. Window coefficients are written one tap at a time through a simple write port. Frames arrive on a valid/ready stream with start and end markers, and the output samples leave on a second valid/ready stream.

Top module: `wola_synth_ola`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, all window coefficients and all accumulator entries are zero, and the frame count f is 0.
- R2: An input sample is taken on each clock edge where in_valid and in_ready are both 1. A sample with in_first=1 goes to position 0, and any other sample goes to the next position. The frame closes when position N-1 is written. From that edge until the last of its R outputs is taken, in_ready is 0.
- R3: A sample with in_last=1 written to a position below N-1 throws away the partial frame. No output results, f does not change, and the next sample goes to position 0.
- R4: For frame x[0..N-1] with count f, the un-rotated frame is u[j] = x[(j + S) mod N], where S = (f*R) mod N. f counts the frames closed since reset.
- R5: Tap m (0 <= m < W) receives e[m] = u[m mod N], and its product is p[m] = e[m]*h[m]. Here h[m] is the signed 16-bit coefficient of tap m, in Q1.15.
- R6: When odd_stack is 1 while the frame is accumulated, e[m] is negated for every odd m.
- R7: acc[m] += p[m] for every m. The R outputs are then acc[0], acc[1] .. acc[R-1] in that order. After that the accumulator moves down by R entries, and the top R entries become zero.
- R8: Each output is y = floor((acc + 16384) / 32768), clamped to the range -32768..32767.
- R9: While out_valid is 1 and out_ready is 0, out_data holds its value. A sample counts as taken only on an edge where both are 1.
- R10: On a clock edge with coef_we=1, coef_data becomes coefficient h[coef_addr], and every frame accumulated after that edge uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| odd_stack | input | 1 | Alternate-tap sign flip for odd stacking |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(W) | Tap index to write |
| coef_data | input | CW | Signed Q1.15 coefficient |
| in_valid | input | 1 | Frame sample valid |
| in_ready | output | 1 | Block accepts frame samples |
| in_first | input | 1 | Sample is position 0 of a frame |
| in_last | input | 1 | Sample ends the frame |
| in_data | input | DW | Signed frame sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | DW | Rounded, saturated output sample |

## Verification
The embedded properties assume that odd_stack and the coefficients stay still while a frame is being accumulated, and that the consumer only drops out_ready without any other rule. The accumulator headroom also assumes that at most W/R frames overlap in any entry. The bench changes coefficients and odd_stack only while the block waits for input. Its stall patterns vary out_ready freely during output, and its input values, even the full-scale ones, keep every sum within the accumulator width.

// File: rtl/wola_syn_pkg.sv
package wola_syn_pkg;
   typedef enum logic [1:0] {
      PH_LOAD = 2'd0,
      PH_MAC  = 2'd1,
      PH_EMIT = 2'd2
   } wola_phase_e;
endpackage

// File: rtl/wola_frame_store.sv
module wola_frame_store #(
   parameter int N  = 32,
   parameter int DW = 16,
   localparam int LN = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [LN-1:0]        wr_idx,
   input  logic signed [DW-1:0] wr_data,
   input  logic [LN-1:0]        rd_idx,
   output logic signed [DW-1:0] rd_data
);
   logic signed [DW-1:0] mem [N];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/wola_window_mac.sv
module wola_window_mac #(
   parameter int W  = 32,
   parameter int DW = 16,
   parameter int CW = 16,
   localparam int TW = $clog2(W),
   localparam int PW = DW + CW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 coef_we,
   input  logic [TW-1:0]        coef_addr,
   input  logic signed [CW-1:0] coef_data,
   input  logic [TW-1:0]        tap,
   input  logic signed [DW-1:0] sample,
   input  logic                 negate,
   output logic signed [PW-1:0] product
);
   logic signed [CW-1:0]    coef [W];
   logic signed [DW+CW-1:0] raw;
   logic signed [PW-1:0]    raw_ext;

   for (genvar g = 0; g < W; g++) begin : g_coef
      always_ff @(posedge clk) begin
         if (!rst_n) coef[g] <= '0;
         else if (coef_we && coef_addr == TW'(g)) coef[g] <= coef_data;
      end
   end

   always_comb begin
      raw     = sample * coef[tap];
      raw_ext = {raw[DW+CW-1], raw};
      product = negate ? -raw_ext : raw_ext;
   end
endmodule

// File: rtl/wola_ola_shifter.sv
module wola_ola_shifter #(
   parameter int W    = 32,
   parameter int PW   = 33,
   parameter int AW   = 36,
   parameter int DW   = 16,
   parameter int FRAC = 15,
   localparam int TW  = $clog2(W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 add_en,
   input  logic [TW-1:0]        add_idx,
   input  logic signed [PW-1:0] add_val,
   input  logic                 shift_en,
   output logic signed [DW-1:0] head_out
);
   localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
   localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW-1:0] MINV = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [AW-1:0] acc [W];
   logic signed [AW-1:0] add_ext;
   logic signed [AW-1:0] rsum;
   logic signed [AW-1:0] rshift;

   assign add_ext = {{(AW-PW){add_val[PW-1]}}, add_val};

   for (genvar g = 0; g < W; g++) begin : g_acc
      if (g == W - 1) begin : g_top
         always_ff @(posedge clk) begin
            if (!rst_n) acc[g] <= '0;
            else if (add_en && add_idx == TW'(g)) acc[g] <= acc[g] + add_ext;
            else if (shift_en) acc[g] <= '0;
         end
      end else begin : g_mid
         always_ff @(posedge clk) begin
            if (!rst_n) acc[g] <= '0;
            else if (add_en && add_idx == TW'(g)) acc[g] <= acc[g] + add_ext;
            else if (shift_en) acc[g] <= acc[g+1];
         end
      end
   end

   always_comb begin
      rsum   = acc[0] + HALF;
      rshift = rsum >>> FRAC;
      if (rshift > MAXV)      head_out = MAXV[DW-1:0];
      else if (rshift < MINV) head_out = MINV[DW-1:0];
      else                    head_out = rshift[DW-1:0];
   end

   assert_tail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> acc[W-1] == '0);
   assert_no_add_during_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(add_en && shift_en));
endmodule

// File: rtl/wola_synth_ola.sv
module wola_synth_ola
   import wola_syn_pkg::*;
#(
   parameter int N  = 32,
   parameter int R  = 8,
   parameter int L  = 128,
   parameter int DW = 16,
   parameter int CW = 16,
   localparam int OS = N / R,
   localparam int W  = L / OS,
   localparam int TW = $clog2(W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 odd_stack,
   input  logic                 coef_we,
   input  logic [TW-1:0]        coef_addr,
   input  logic signed [CW-1:0] coef_data,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_first,
   input  logic                 in_last,
   input  logic signed [DW-1:0] in_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic signed [DW-1:0] out_data
);
   localparam int LN   = $clog2(N);
   localparam int EW   = $clog2(R);
   localparam int PW   = DW + CW + 1;
   localparam int AW   = PW + $clog2(W / R) + 1;
   localparam int FRAC = CW - 1;

   if ((N & (N - 1)) != 0 || N < 2) begin : g_bad_n
      $error("N must be a power of two of at least 2");
   end
   if ((R & (R - 1)) != 0 || R < 2 || R > N) begin : g_bad_r
      $error("R must be a power of two between 2 and N");
   end
   if (L % OS != 0 || W < R) begin : g_bad_l
      $error("L must divide by N/R and give at least R taps");
   end

   wola_phase_e          state;
   logic [LN-1:0]        cnt;
   logic [LN-1:0]        rot;
   logic [TW-1:0]        tap;
   logic [EW-1:0]        ecnt;
   logic                 fire;
   logic [LN-1:0]        wr_idx;
   logic [TW+LN-1:0]     tap_wide;
   logic [LN-1:0]        rd_idx;
   logic signed [DW-1:0] rd_data;
   logic signed [PW-1:0] product;
   logic                 shift_en;

   assign in_ready  = (state == PH_LOAD);
   assign out_valid = (state == PH_EMIT);
   assign fire      = in_valid && in_ready;
   assign wr_idx    = in_first ? '0 : cnt;
   assign tap_wide  = {{LN{1'b0}}, tap};
   assign rd_idx    = tap_wide[LN-1:0] + rot;
   assign shift_en  = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= PH_LOAD;
         cnt   <= '0;
         rot   <= '0;
         tap   <= '0;
         ecnt  <= '0;
      end else begin
         unique case (state)
            PH_LOAD: if (fire) begin
               if (wr_idx == LN'(N - 1)) begin
                  state <= PH_MAC;
                  tap   <= '0;
                  cnt   <= '0;
               end else if (in_last) begin
                  cnt <= '0;
               end else begin
                  cnt <= wr_idx + 1'b1;
               end
            end
            PH_MAC: begin
               if (tap == TW'(W - 1)) begin
                  state <= PH_EMIT;
                  rot   <= rot + LN'(R);
                  ecnt  <= '0;
               end else begin
                  tap <= tap + 1'b1;
               end
            end
            PH_EMIT: if (out_ready) begin
               if (ecnt == EW'(R - 1)) state <= PH_LOAD;
               else ecnt <= ecnt + 1'b1;
            end
            default: state <= PH_LOAD;
         endcase
      end
   end

   wola_frame_store #(.N(N), .DW(DW)) u_store (
      .clk     (clk),
      .wr_en   (fire),
      .wr_idx  (wr_idx),
      .wr_data (in_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   wola_window_mac #(.W(W), .DW(DW), .CW(CW)) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .coef_we   (coef_we),
      .coef_addr (coef_addr),
      .coef_data (coef_data),
      .tap       (tap),
      .sample    (rd_data),
      .negate    (odd_stack && tap[0]),
      .product   (product)
   );

   wola_ola_shifter #(.W(W), .PW(PW), .AW(AW), .DW(DW), .FRAC(FRAC)) u_ola (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_en   (state == PH_MAC),
      .add_idx  (tap),
      .add_val  (product),
      .shift_en (shift_en),
      .head_out (out_data)
   );

   assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   assert_ports_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));
   assert_rotation_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_MAC && tap == TW'(W - 1)) |=> (rot == $past(rot) + LN'(R)));
endmodule

// File: tb/wola_synth_ola_test.sv
`timescale 1ns/1ps
module wola_synth_ola_test;
   localparam int N = 32, R = 8, L = 128, DW = 16, CW = 16;
   localparam int W = L / (N / R);
   localparam int TW = $clog2(W);

   logic clk = 0, rst_n = 0;
   logic odd_stack = 0, coef_we = 0;
   logic [TW-1:0] coef_addr = '0;
   logic signed [CW-1:0] coef_data = '0;
   logic in_valid = 0, in_first = 0, in_last = 0, out_ready = 0;
   logic signed [DW-1:0] in_data = '0;
   logic in_ready, out_valid;
   logic signed [DW-1:0] out_data;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   int h [W];
   longint macc [W];
   int fx [N];
   int fidx = 0;
   int exp_o [R];

   always #10 clk = ~clk;

   wola_synth_ola #(.N(N), .R(R), .L(L), .DW(DW), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .odd_stack(odd_stack),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
      .in_last(in_last), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

   task automatic check(bit ok, string req, longint act, longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int rnd_sat(longint a);
      longint v = (a + 64'sd16384) >>> 15;
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   task automatic load_coef(int m, int v);
      h[m] = v;
      coef_we = 1; coef_addr = TW'(m); coef_data = CW'(v);
      @(negedge clk);
      coef_we = 0;
   endtask

   task automatic drive_sample(int d, bit f, bit l);
      in_valid = 1; in_data = DW'(d); in_first = f; in_last = l;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 0; in_first = 0; in_last = 0;
   endtask

   task automatic send_frame();
      for (int i = 0; i < N; i++) drive_sample(fx[i], i == 0, i == N - 1);
   endtask

   task automatic model_frame(bit odd);
      int s = (fidx * R) % N;
      for (int m = 0; m < W; m++) begin
         longint e = fx[((m % N) + s) % N];
         if (odd && (m % 2 == 1)) e = -e;
         macc[m] += e * h[m];
      end
      for (int k = 0; k < R; k++) exp_o[k] = rnd_sat(macc[k]);
      for (int m = 0; m < W; m++) macc[m] = (m + R < W) ? macc[m + R] : 0;
      fidx++;
   endtask

   task automatic collect(bit stall, string tag);
      int got = 0, cyc = 0, held = 0;
      bit holding = 0;
      while (got < R) begin
         out_ready = (stall && (cyc % 3 != 0)) ? 1'b0 : 1'b1;
         cyc++;
         if (out_valid) begin
            check(!in_ready, "R2 in_ready low during output", in_ready, 0);
            if (holding) check(out_data == held, "R9 held data", out_data, held);
            if (out_ready) begin
               check(out_data == exp_o[got], tag, out_data, exp_o[got]);
               got++;
               holding = 0;
            end else begin
               holding = 1;
               held = out_data;
            end
         end
         @(negedge clk);
      end
      out_ready = 0;
   endtask

   task automatic run_frame(bit odd, bit stall, string tag);
      odd_stack = odd;
      send_frame();
      model_frame(odd);
      collect(stall, tag);
      odd_stack = 0;
   endtask

   task automatic test_reset();
      check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
      check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
      for (int i = 0; i < N; i++) fx[i] = 1000 + 37 * i;
      run_frame(0, 0, "R1 zero coefficients and accumulator");
   endtask

   task automatic test_coef();
      for (int m = 0; m < W; m++) load_coef(m, 1000 * m - 9000);
      for (int i = 0; i < N; i++) fx[i] = (i * 731) % 2000 - 1000;
      run_frame(0, 0, "R10 R5 loaded window");
   endtask

   task automatic test_rotation();
      for (int t = 0; t < 5; t++) begin
         for (int i = 0; i < N; i++) fx[i] = 0;
         fx[(3 * t + 1) % N] = 3000;
         fx[(5 * t + 7) % N] = -1200;
         run_frame(0, 0, "R4 rotation over frames");
      end
   endtask

   task automatic test_odd();
      for (int t = 0; t < 2; t++) begin
         for (int i = 0; i < N; i++) fx[i] = 500 + 11 * i - 40 * t;
         run_frame(1, 0, "R6 odd stacking");
      end
   endtask

   task automatic test_stall();
      for (int t = 0; t < 2; t++) begin
         for (int i = 0; i < N; i++) fx[i] = (i * 97 + t * 13) % 4001 - 2000;
         run_frame(0, 1, "R7 R9 stalled output");
      end
   endtask

   task automatic test_abort();
      for (int i = 0; i < 5; i++) drive_sample(9999, i == 0, i == 4);
      check(in_ready == 1, "R3 still loading after early last", in_ready, 1);
      check(out_valid == 0, "R3 no output after early last", out_valid, 0);
      for (int i = 0; i < 3; i++) drive_sample(-7777, 0, 0);
      check(out_valid == 0, "R2 partial frame gives no output", out_valid, 0);
      for (int i = 0; i < N; i++) fx[i] = 200 * (i % 7) - 600;
      run_frame(0, 0, "R3 R2 frame after discard and first");
   endtask

   task automatic test_round();
      for (int i = 0; i < N; i++) fx[i] = 0;
      for (int t = 0; t < W / R; t++) run_frame(0, 0, "R7 flush with zeros");
      for (int m = 0; m < W; m++) load_coef(m, 16384);
      for (int i = 0; i < N; i++) fx[i] = (i % 2 == 0) ? 1 : -1;
      run_frame(0, 0, "R8 rounding at half");
   endtask

   task automatic test_saturate();
      int sat_seen = 0;
      for (int m = 0; m < W; m++) load_coef(m, 32767);
      for (int t = 0; t < 6; t++) begin
         for (int i = 0; i < N; i++) fx[i] = (t < 3) ? 32767 : -32768;
         run_frame(0, 0, "R8 saturation");
         if (exp_o[0] == 32767 || exp_o[0] == -32768) sat_seen++;
      end
      check(sat_seen >= 4, "R8 clamp reached", sat_seen, 4);
   endtask

   initial begin
      for (int m = 0; m < W; m++) begin h[m] = 0; macc[m] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      test_reset();
      test_coef();
      test_rotation();
      test_odd();
      test_stall();
      test_abort();
      test_round();
      test_saturate();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule